// File: doc/BRIEF.md
# Quad-Core Cluster Configuration Registers

This block is a small memory-mapped register window that sits beside a four-core processor cluster. Boot firmware uses it to store a start address for secondary cores and to release them. Writing a nonzero word to a core's reset-control slot sends a one-cycle bring-up request for that core. The request carries the stored start address and a fixed target exception level. Beyond that, the window holds a general control word and a standby flag as read/write storage.

The remaining slots are hard-wired. The per-core reset, status and control slots, the cluster and system reset slots, and the clock-gating slot return fixed values and drop writes. A small set of slots is reserved but not implemented: access to them returns zero and raises an unimplemented pulse. Any other offset raises an out-of-range pulse. Every access is a full 32-bit word. A partial access is refused and raises its own error pulse.

The bus side is a valid/ready handshake. An accepted access is answered with a one-cycle response in the next clock cycle.

Top module: `core_cfg_regs`

## Requirements
- R1: After reset, `bus_ready` is high and no pulse output is active. The general control word reads 0x20 (offset 0x184), the standby flag reads 0 (offset 0x1A0) and the start address reads 0 (offset 0x1A4).
- R2: The general control word, the standby flag and the start address store a full-word write. Each reads the stored value back until it is written again.
- R3: The following slots read fixed values:
  - offsets 0x000 and 0x140 read 0x1;
  - each core reset-control slot (0x040 + 0x40·n, n = 0..3) reads 0x3;
  - each core control slot (reset slot + 4) reads 0;
  - each core status slot (reset slot + 8) reads 0x1;
  - offset 0x144 reads 0x10F.
- R4: Writes to the fixed-value slots of R3 change nothing; a later read returns the same fixed value.
- R5: A full-word write of a nonzero value to core n's reset-control slot makes bit n of `boot_req` high for exactly the one cycle after acceptance. Writing zero raises no request.
- R6: While a bit of `boot_req` is high, `boot_addr` equals the start address stored before that write and `boot_el` equals 3. `boot_addr` holds its value afterwards.
- R7: Offsets 0x1E4, 0x280, 0x284 and 0x288 read 0, ignore writes and pulse `unimp_pulse` in the response cycle. This holds for both reads and writes.
- R8: Any offset not named in R1–R7 reads 0, ignores writes and pulses `range_err_pulse` in the response cycle. Misaligned offsets are included.
- R9: An access whose `bus_be` is not 4'b1111 is refused:
  - a write stores nothing and raises no bring-up request;
  - a read returns 0;
  - only `size_err_pulse` is raised.
- R10: `rsp_valid` is high exactly in the cycle after each accepted access. A write response carries `rsp_rdata` = 0.
- R11: Reading a core reset-control slot raises no bring-up request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Block can accept an access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset in the 1 KiB window |
| bus_be | input | 4 | Byte enables; must be all ones |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle marker |
| rsp_rdata | output | 32 | Read data |
| boot_req | output | 4 | Per-core bring-up request pulse |
| boot_addr | output | 32 | Start address for the request |
| boot_el | output | 2 | Target exception level (3) |
| unimp_pulse | output | 1 | Unimplemented-slot access |
| range_err_pulse | output | 1 | Out-of-range access |
| size_err_pulse | output | 1 | Partial-width access refused |

## Verification
The hardest case to reach is a bring-up request that must carry a start address written only one access earlier. The stimulus writes the start address and then the core's reset slot in consecutive accepted cycles. This checks that the request sees the freshly stored value and not the reset value. Partial-width writes to a reset slot and to the start address are issued as well. They confirm that a refused access neither launches a core nor disturbs the stored address, which only the next request and readback can reveal.

// File: rtl/ccfg_pkg.sv
package ccfg_pkg;

  typedef enum logic [3:0] {
    K_CLUSTER_RST,
    K_CORE_RST,
    K_CORE_CTRL,
    K_CORE_STAT,
    K_CLK_GATE,
    K_GEN_CTRL,
    K_STANDBY,
    K_ENTRY,
    K_UNIMP,
    K_NONE
  } reg_kind_e;

  localparam int unsigned OFS_CLUSTER_RST = 'h000;
  localparam int unsigned OFS_SYS_RST     = 'h140;
  localparam int unsigned OFS_CLK_GATE    = 'h144;
  localparam int unsigned OFS_GEN_CTRL    = 'h184;
  localparam int unsigned OFS_STANDBY     = 'h1A0;
  localparam int unsigned OFS_ENTRY       = 'h1A4;
  localparam int unsigned OFS_DEBUG       = 'h1E4;
  localparam int unsigned OFS_TMR_CTRL    = 'h280;
  localparam int unsigned OFS_TMR_LO      = 'h284;
  localparam int unsigned OFS_TMR_HI      = 'h288;

  localparam int unsigned CORE_BASE   = 'h040;
  localparam int unsigned CORE_STRIDE = 'h040;
  localparam int unsigned CORE_CTRL_D = 4;
  localparam int unsigned CORE_STAT_D = 8;

  localparam logic [31:0] VAL_CLUSTER_RST = 32'h0000_0001;
  localparam logic [31:0] VAL_CORE_RST    = 32'h0000_0003;
  localparam logic [31:0] VAL_CORE_STAT   = 32'h0000_0001;
  localparam logic [31:0] VAL_CLK_GATE    = 32'h0000_010F;

endpackage

// File: rtl/ccfg_decode.sv
module ccfg_decode
  import ccfg_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 10,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  core_idx
);

  always_comb begin
    kind     = K_NONE;
    core_idx = '0;
    unique case (addr)
      ADDR_W'(OFS_CLUSTER_RST),
      ADDR_W'(OFS_SYS_RST):  kind = K_CLUSTER_RST;
      ADDR_W'(OFS_CLK_GATE): kind = K_CLK_GATE;
      ADDR_W'(OFS_GEN_CTRL): kind = K_GEN_CTRL;
      ADDR_W'(OFS_STANDBY):  kind = K_STANDBY;
      ADDR_W'(OFS_ENTRY):    kind = K_ENTRY;
      ADDR_W'(OFS_DEBUG),
      ADDR_W'(OFS_TMR_CTRL),
      ADDR_W'(OFS_TMR_LO),
      ADDR_W'(OFS_TMR_HI):   kind = K_UNIMP;
      default:               kind = K_NONE;
    endcase
    // Per-core slots; the loop index is the core number, i.e. (offset - base) >> 6.
    for (int i = 0; i < NUM_CORES; i++) begin
      if (addr == ADDR_W'(CORE_BASE + i * CORE_STRIDE)) begin
        kind     = K_CORE_RST;
        core_idx = IDX_W'(i);
      end
      if (addr == ADDR_W'(CORE_BASE + i * CORE_STRIDE + CORE_CTRL_D)) begin
        kind     = K_CORE_CTRL;
        core_idx = IDX_W'(i);
      end
      if (addr == ADDR_W'(CORE_BASE + i * CORE_STRIDE + CORE_STAT_D)) begin
        kind     = K_CORE_STAT;
        core_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/ccfg_store.sv
module ccfg_store
  import ccfg_pkg::*;
#(
  parameter int          DATA_W       = 32,
  parameter logic [31:0] GEN_CTRL_RST = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_kind_e         kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] gen_ctrl_q,
  output logic [DATA_W-1:0] standby_q,
  output logic [DATA_W-1:0] entry_q
);

  logic [DATA_W-1:0] gen_ctrl_d, standby_d, entry_d;
  logic              gen_en, standby_en, entry_en;

  always_comb begin
    gen_en     = wr_en && (kind == K_GEN_CTRL);
    standby_en = wr_en && (kind == K_STANDBY);
    entry_en   = wr_en && (kind == K_ENTRY);
    gen_ctrl_d = gen_en     ? wdata : gen_ctrl_q;
    standby_d  = standby_en ? wdata : standby_q;
    entry_d    = entry_en   ? wdata : entry_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_ctrl_q <= DATA_W'(GEN_CTRL_RST);
      standby_q  <= '0;
      entry_q    <= '0;
    end else begin
      gen_ctrl_q <= gen_ctrl_d;
      standby_q  <= standby_d;
      entry_q    <= entry_d;
    end
  end

endmodule

// File: rtl/ccfg_launch.sv
module ccfg_launch #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [IDX_W-1:0]  core_idx,
  input  logic [DATA_W-1:0] entry,
  output logic [NUM_CORES-1:0] boot_req,
  output logic [DATA_W-1:0] boot_addr
);

  logic [NUM_CORES-1:0] req_d;
  logic [DATA_W-1:0]    addr_d;

  always_comb begin
    req_d = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      req_d[i] = fire && (core_idx == IDX_W'(i));
    end
    addr_d = fire ? entry : boot_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_req  <= '0;
      boot_addr <= '0;
    end else begin
      boot_req  <= req_d;
      boot_addr <= addr_d;
    end
  end

endmodule

// File: rtl/core_cfg_regs.sv
module core_cfg_regs
  import ccfg_pkg::*;
#(
  parameter int          NUM_CORES    = 4,
  parameter int          ADDR_W       = 10,
  parameter int          DATA_W       = 32,
  parameter logic [1:0]  BOOT_EL      = 2'd3,
  parameter logic [31:0] GEN_CTRL_RST = 32'h0000_0020,
  localparam int         BE_W         = DATA_W / 8,
  localparam int         IDX_W        = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  output logic                 bus_ready,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BE_W-1:0]      bus_be,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NUM_CORES-1:0] boot_req,
  output logic [DATA_W-1:0]    boot_addr,
  output logic [1:0]           boot_el,
  output logic                 unimp_pulse,
  output logic                 range_err_pulse,
  output logic                 size_err_pulse
);

  reg_kind_e         kind;
  logic [IDX_W-1:0]  core_idx;
  logic [DATA_W-1:0] gen_ctrl_q, standby_q, entry_q;
  logic              accept, full_word, wr_ok, fire;
  logic [DATA_W-1:0] rd_mux;
  logic              rdy_d, rsp_valid_d, unimp_d, range_d, size_d;
  logic [DATA_W-1:0] rdata_d;

  ccfg_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .kind     (kind),
    .core_idx (core_idx)
  );

  always_comb begin
    accept    = bus_valid && bus_ready;
    full_word = (bus_be == {BE_W{1'b1}});
    wr_ok     = accept && bus_write && full_word;
    fire      = wr_ok && (kind == K_CORE_RST) && (bus_wdata != '0);
  end

  ccfg_store #(.DATA_W(DATA_W), .GEN_CTRL_RST(GEN_CTRL_RST)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_ok),
    .kind       (kind),
    .wdata      (bus_wdata),
    .gen_ctrl_q (gen_ctrl_q),
    .standby_q  (standby_q),
    .entry_q    (entry_q)
  );

  ccfg_launch #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .core_idx  (core_idx),
    .entry     (entry_q),
    .boot_req  (boot_req),
    .boot_addr (boot_addr)
  );

  assign boot_el = BOOT_EL;

  // Read value for a full-word access, before any write of this cycle.
  always_comb begin
    unique case (kind)
      K_CLUSTER_RST: rd_mux = DATA_W'(VAL_CLUSTER_RST);
      K_CORE_RST:    rd_mux = DATA_W'(VAL_CORE_RST);
      K_CORE_STAT:   rd_mux = DATA_W'(VAL_CORE_STAT);
      K_CLK_GATE:    rd_mux = DATA_W'(VAL_CLK_GATE);
      K_GEN_CTRL:    rd_mux = gen_ctrl_q;
      K_STANDBY:     rd_mux = standby_q;
      K_ENTRY:       rd_mux = entry_q;
      default:       rd_mux = '0;
    endcase
  end

  // Response next-state.
  always_comb begin
    rdy_d       = 1'b1;
    rsp_valid_d = accept;
    rdata_d     = (accept && !bus_write && full_word) ? rd_mux : '0;
    size_d      = accept && !full_word;
    unimp_d     = accept && full_word && (kind == K_UNIMP);
    range_d     = accept && full_word && (kind == K_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready       <= 1'b0;
      rsp_valid       <= 1'b0;
      rsp_rdata       <= '0;
      unimp_pulse     <= 1'b0;
      range_err_pulse <= 1'b0;
      size_err_pulse  <= 1'b0;
    end else begin
      bus_ready       <= rdy_d;
      rsp_valid       <= rsp_valid_d;
      rsp_rdata       <= rdata_d;
      unimp_pulse     <= unimp_d;
      range_err_pulse <= range_d;
      size_err_pulse  <= size_d;
    end
  end

endmodule

// File: rtl/ccfg_checker.sv
module ccfg_checker #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic                 bus_ready,
  input logic                 bus_write,
  input logic                 rsp_valid,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic [NUM_CORES-1:0] boot_req,
  input logic [1:0]           boot_el,
  input logic                 unimp_pulse,
  input logic                 range_err_pulse,
  input logic                 size_err_pulse
);

  // R5: at most one core launched per access
  a_r5_one_core: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(boot_req));

  // R5 / R11: a request only follows an accepted write
  a_r11_req_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write) |=> (boot_req == '0));

  // R6: level carried with every request
  a_r6_level: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_req != '0) |-> (boot_el == 2'd3));

  // R10: response follows acceptance and nothing else
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready) |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_ready) |=> !rsp_valid);

  // R7 / R8 / R9: at most one error class, always inside a response
  a_r9_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({unimp_pulse, range_err_pulse, size_err_pulse}) <= 1);
  a_r8_err_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (unimp_pulse || range_err_pulse || size_err_pulse) |-> (rsp_valid && rsp_rdata == '0));

endmodule

bind core_cfg_regs ccfg_checker #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_ccfg_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_valid       (bus_valid),
  .bus_ready       (bus_ready),
  .bus_write       (bus_write),
  .rsp_valid       (rsp_valid),
  .rsp_rdata       (rsp_rdata),
  .boot_req        (boot_req),
  .boot_el         (boot_el),
  .unimp_pulse     (unimp_pulse),
  .range_err_pulse (range_err_pulse),
  .size_err_pulse  (size_err_pulse)
);

// File: tb/core_cfg_regs_bench.sv
module core_cfg_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  boot_req;
  logic [31:0] boot_addr;
  logic [1:0]  boot_el;
  logic        unimp_pulse, range_err_pulse, size_err_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // captured response
  logic [31:0] c_rdata;
  logic [3:0]  c_boot;
  logic [31:0] c_baddr;
  logic [1:0]  c_el;
  logic        c_rv, c_un, c_rg, c_sz;

  always #2.5 clk = ~clk;

  core_cfg_regs u_core_cfg_regs (
    .clk (clk), .rst_n (rst_n),
    .bus_valid (bus_valid), .bus_ready (bus_ready), .bus_write (bus_write),
    .bus_addr (bus_addr), .bus_be (bus_be), .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .boot_req (boot_req), .boot_addr (boot_addr), .boot_el (boot_el),
    .unimp_pulse (unimp_pulse), .range_err_pulse (range_err_pulse),
    .size_err_pulse (size_err_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [9:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    c_rdata = rsp_rdata; c_boot = boot_req; c_baddr = boot_addr; c_el = boot_el;
    c_rv = rsp_valid; c_un = unimp_pulse; c_rg = range_err_pulse; c_sz = size_err_pulse;
    bus_valid = 1'b0; bus_write = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [9:0] a);
    access(1'b0, a, 4'hF, 32'h0);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    access(1'b1, a, 4'hF, d);
  endtask

  task automatic t_reset();
    chk("R1 ready", {31'b0, bus_ready}, 32'h1);
    chk("R1 no pulses", {26'b0, boot_req, unimp_pulse, range_err_pulse, size_err_pulse}, 32'h0);
    rd(10'h184); chk("R1 gen ctrl", c_rdata, 32'h20);
    rd(10'h1A0); chk("R1 standby", c_rdata, 32'h0);
    rd(10'h1A4); chk("R1 entry", c_rdata, 32'h0);
  endtask

  task automatic t_rw();
    wr(10'h184, 32'hA5A5_0F0F);
    chk("R10 write rdata", c_rdata, 32'h0);
    chk("R10 rsp valid", {31'b0, c_rv}, 32'h1);
    @(negedge clk);
    chk("R10 rsp one cycle", {31'b0, rsp_valid}, 32'h0);
    wr(10'h1A0, 32'h0000_0001);
    wr(10'h1A4, 32'h4000_0100);
    rd(10'h184); chk("R2 gen ctrl", c_rdata, 32'hA5A5_0F0F);
    rd(10'h1A0); chk("R2 standby", c_rdata, 32'h1);
    rd(10'h1A4); chk("R2 entry", c_rdata, 32'h4000_0100);
  endtask

  task automatic t_fixed();
    rd(10'h000); chk("R3 cluster rst", c_rdata, 32'h1);
    rd(10'h140); chk("R3 sys rst", c_rdata, 32'h1);
    rd(10'h144); chk("R3 clk gate", c_rdata, 32'h10F);
    for (int n = 0; n < 4; n++) begin
      rd(10'(10'h40 + n * 10'h40)); chk("R3 core rst", c_rdata, 32'h3);
      chk("R11 read no boot", {28'b0, c_boot}, 32'h0);
      rd(10'(10'h44 + n * 10'h40)); chk("R3 core ctrl", c_rdata, 32'h0);
      rd(10'(10'h48 + n * 10'h40)); chk("R3 core stat", c_rdata, 32'h1);
    end
    wr(10'h144, 32'hFFFF_FFFF); rd(10'h144); chk("R4 clk gate", c_rdata, 32'h10F);
    wr(10'h088, 32'h0000_0000); rd(10'h088); chk("R4 core stat", c_rdata, 32'h1);
    wr(10'h0C4, 32'h1234_5678); rd(10'h0C4); chk("R4 core ctrl", c_rdata, 32'h0);
    wr(10'h000, 32'h0);         rd(10'h000); chk("R4 cluster rst", c_rdata, 32'h1);
  endtask

  task automatic t_boot();
    for (int n = 0; n < 4; n++) begin
      wr(10'h1A4, 32'h8000_0000 + 32'(n * 16));
      wr(10'(10'h40 + n * 10'h40), 32'h0000_0001 << n);
      chk("R5 boot bit", {28'b0, c_boot}, 32'h1 << n);
      chk("R6 boot addr", c_baddr, 32'h8000_0000 + 32'(n * 16));
      chk("R6 boot el", {30'b0, c_el}, 32'h3);
      @(negedge clk);
      chk("R5 one cycle", {28'b0, boot_req}, 32'h0);
      chk("R6 addr held", boot_addr, 32'h8000_0000 + 32'(n * 16));
    end
    wr(10'h080, 32'h0); chk("R5 zero write", {28'b0, c_boot}, 32'h0);
  endtask

  task automatic t_unimp();
    wr(10'h1E4, 32'hFFFF_FFFF); chk("R7 write pulse", {31'b0, c_un}, 32'h1);
    rd(10'h1E4); chk("R7 debug read", c_rdata, 32'h0);
    rd(10'h280); chk("R7 ctrl pulse", {31'b0, c_un}, 32'h1);
    rd(10'h284); chk("R7 lo read", c_rdata, 32'h0);
    rd(10'h288); chk("R7 hi pulse", {31'b0, c_un}, 32'h1);
    chk("R7 no range", {31'b0, c_rg}, 32'h0);
  endtask

  task automatic t_range();
    rd(10'h3FC); chk("R8 read pulse", {31'b0, c_rg}, 32'h1);
    chk("R8 read zero", c_rdata, 32'h0);
    wr(10'h1A8, 32'hDEAD_BEEF); chk("R8 write pulse", {31'b0, c_rg}, 32'h1);
    rd(10'h1A8); chk("R8 still zero", c_rdata, 32'h0);
    rd(10'h186); chk("R8 misaligned", {31'b0, c_rg}, 32'h1);
    chk("R8 no unimp", {31'b0, c_un}, 32'h0);
  endtask

  task automatic t_partial();
    wr(10'h1A4, 32'h1111_2222);
    access(1'b1, 10'h1A4, 4'h3, 32'h9999_9999);
    chk("R9 size pulse", {31'b0, c_sz}, 32'h1);
    chk("R9 no other", {30'b0, c_un, c_rg}, 32'h0);
    rd(10'h1A4); chk("R9 entry kept", c_rdata, 32'h1111_2222);
    access(1'b1, 10'h100, 4'h1, 32'h1);
    chk("R9 no boot", {28'b0, c_boot}, 32'h0);
    access(1'b0, 10'h184, 4'hE, 32'h0);
    chk("R9 read zero", c_rdata, 32'h0);
    chk("R9 read pulse", {31'b0, c_sz}, 32'h1);
    access(1'b0, 10'h3FC, 4'h0, 32'h0);
    chk("R9 beats range", {30'b0, c_rg, c_sz}, 32'h1);
    // back-to-back: new entry address then launch core 3
    wr(10'h1A4, 32'h0BAD_F00D);
    wr(10'h100, 32'h8000_0000);
    chk("R6 fresh addr", c_baddr, 32'h0BAD_F00D);
    chk("R5 core3", {28'b0, c_boot}, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rw();
    t_fixed();
    t_boot();
    t_unimp();
    t_range();
    t_partial();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule